// File: doc/BRIEF.md
# I2C Slave Receiver and Transmitter

This block is the target side of a two-wire serial bus. It runs entirely on the system clock: both bus lines pass through a synchroniser, and the block finds clock edges and the bus start and stop conditions from the synchronised samples. After a start it shifts in a seven-bit address followed by a direction bit. It compares that address with an address register that can be written at run time. On a match it acknowledges, then receives or sends bytes depending on the direction bit.

Bytes that arrive appear on a parallel output with a one-cycle valid pulse. Bytes to send are taken from a parallel input at the moment the slave needs the next byte, and a pulse marks each time it takes one. The data line is open-drain: the block only reports when it wants the line pulled low, and the pad or the board wires that with the other drivers and the pull-up.

Top module: `i2c_slave_core`

## Requirements
- R1: After reset, `sdaDriveLow` and `rxValid` are 0 and the slave waits for a START.
- R2: A START is a falling SDA while SCL is high. The first byte after it is sent MSB first and holds seven address bits and then a direction bit. When those seven bits equal `ownAddrIn[7:1]` as last loaded, the slave pulls SDA low during the ninth clock. Bit 0 of the stored address takes no part in the compare.
- R3: With direction bit 0, each later byte is shifted in MSB first. It appears on `rxData` together with a `rxValid` pulse exactly one clock long, and the slave pulls SDA low in that byte's ninth clock.
- R4: When the address does not match, the slave drives nothing, raises no `rxValid` and acknowledges nothing until the next START.
- R5: With direction bit 1, the slave drives `txData` MSB first. It samples `txData` on the SCL fall that closes the address acknowledge, or the SCL fall that closes a master ACK, and pulses `txTaken` for each byte it takes.
- R6: In transmit mode, when the master leaves the ninth bit high (NACK), the slave releases SDA and drives nothing more until the next START.
- R7: A START that arrives while a transfer is under way, even in the middle of a byte, drops that byte and starts address reception again.
- R8: A STOP is a rising SDA while SCL is high. It returns the slave to idle, and any bits clocked after it without a START are ignored.
- R9: The slave starts pulling SDA low only while SCL is low.
- R10: A pulse on `ownAddrWr` loads `ownAddrIn` into the address register, and the new value applies from the next address phase on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus lines are oversampled on it |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaDriveLow | output | 1 | 1 asks the pad to pull SDA low, 0 releases it |
| ownAddrWr | input | 1 | Load strobe for the own-address register |
| ownAddrIn | input | 8 | New own-address value, address in bits [7:1] |
| txData | input | 8 | Next byte to send in transmit mode |
| txTaken | output | 1 | One-cycle pulse when `txData` has been sampled |
| rxData | output | 8 | Last byte received |
| rxValid | output | 1 | One-cycle pulse when `rxData` holds a new byte |

## Verification
The bench builds the core with three synchroniser stages, one more than the default, so the edge and condition logic is checked with the extra latency between a pad edge and the slave's reaction. The reset address is set to 0x54, which puts address 0x2A in bits [7:1]. This lets the first transfers run before any register write, and the run-time write later moves the slave to 0x7F with bit 0 set, which shows that bit 0 is left out of the compare. Each bus phase lasts ten system clocks, so the synchroniser delay stays well inside a low phase, and the drive timing and the master-side sampling of acknowledges and transmitted bits both happen at known points.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } state_e;

  // events seen on the synchronised bus lines
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startCond;
    logic stopCond;
  } busEv_t;

  // control to datapath strobes
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic emitRx;
    logic ackDrive;
    logic dataDrive;
  } strobe_t;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  output busEv_t ev,
  output logic   sdaBit
);

  localparam int LINES = 2;
  localparam int SCL_IDX = 1;
  localparam int SDA_IDX = 0;

  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] syncLines;
  logic [LINES-1:0] prevLines;

  assign rawLines = {sclIn, sdaIn};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawLines[l]};
    end
    assign syncLines[l] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLines <= '1;
    else       prevLines <= syncLines;
  end

  logic sclNow, sclOld, sdaNow, sdaOld;
  assign sclNow = syncLines[SCL_IDX];
  assign sclOld = prevLines[SCL_IDX];
  assign sdaNow = syncLines[SDA_IDX];
  assign sdaOld = prevLines[SDA_IDX];

  always_comb begin
    ev.sclRise   = sclNow & ~sclOld;
    ev.sclFall   = ~sclNow & sclOld;
    ev.startCond = sclNow & sclOld & sdaOld & ~sdaNow;
    ev.stopCond  = sclNow & sclOld & ~sdaOld & sdaNow;
  end

  assign sdaBit = sdaNow;

endmodule

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter logic [7:0]  OWN_ADDR_RST = 8'hA0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              sdaBit,
  input  logic              ownAddrWr,
  input  logic [DATA_W-1:0] ownAddrIn,
  input  logic [DATA_W-1:0] txData,
  output logic              cntFull,
  output logic              cntLast,
  output logic              addrHit,
  output logic              rwBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              txTaken,
  output logic              sdaDriveLow
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [DATA_W-1:0] ADDR_MASK = {{(DATA_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] ownAddrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ownAddrQ <= DATA_W'(OWN_ADDR_RST);
    else if (ownAddrWr) ownAddrQ <= ownAddrIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          bitCnt <= '0;
    else if (st.clrCnt) bitCnt <= '0;
    else if (st.incCnt) bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shiftReg <= '0;
    else if (st.loadTx)   shiftReg <= txData;
    else if (st.shiftIn)  shiftReg <= {shiftReg[DATA_W-2:0], sdaBit};
    else if (st.shiftOut) shiftReg <= {shiftReg[DATA_W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxValid <= 1'b0;
      txTaken <= 1'b0;
    end else begin
      rxValid <= st.emitRx;
      txTaken <= st.loadTx;
      if (st.emitRx) rxData <= {shiftReg[DATA_W-2:0], sdaBit};
    end
  end

  assign cntFull     = (bitCnt == CNT_FULL);
  assign cntLast     = (bitCnt == CNT_LAST);
  assign addrHit     = ((shiftReg ^ ownAddrQ) & ADDR_MASK) == '0;
  assign rwBit       = shiftReg[0];
  assign sdaDriveLow = st.ackDrive | (st.dataDrive & ~shiftReg[DATA_W-1]);

endmodule

// File: rtl/i2cs_control.sv
module i2cs_control
  import i2cs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  busEv_t  ev,
  input  logic    sdaBit,
  input  logic    cntFull,
  input  logic    cntLast,
  input  logic    addrHit,
  input  logic    rwBit,
  output strobe_t st,
  output state_e  state
);

  state_e nextState;
  logic   masterAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // master acknowledge captured on the ninth rising edge of a sent byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      masterAck <= 1'b0;
    else if (state == ST_TX_ACK && ev.sclRise)
      masterAck <= ~sdaBit;
  end

  always_comb begin
    st        = '0;
    nextState = state;
    if (ev.startCond) begin
      st.clrCnt = 1'b1;
      nextState = ST_ADDR;
    end else if (ev.stopCond) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE, ST_SKIP: ;
        ST_ADDR: begin
          if (ev.sclRise) begin
            st.shiftIn = 1'b1;
            st.incCnt  = 1'b1;
          end
          if (ev.sclFall && cntFull)
            nextState = addrHit ? ST_ADDR_ACK : ST_SKIP;
        end
        ST_ADDR_ACK: begin
          st.ackDrive = 1'b1;
          if (ev.sclFall) begin
            st.clrCnt = 1'b1;
            if (rwBit) begin
              st.loadTx = 1'b1;
              nextState = ST_TX;
            end else begin
              nextState = ST_RX;
            end
          end
        end
        ST_RX: begin
          if (ev.sclRise) begin
            st.shiftIn = 1'b1;
            st.incCnt  = 1'b1;
            st.emitRx  = cntLast;
          end
          if (ev.sclFall && cntFull) nextState = ST_RX_ACK;
        end
        ST_RX_ACK: begin
          st.ackDrive = 1'b1;
          if (ev.sclFall) begin
            st.clrCnt = 1'b1;
            nextState = ST_RX;
          end
        end
        ST_TX: begin
          st.dataDrive = 1'b1;
          if (ev.sclRise) st.incCnt = 1'b1;
          if (ev.sclFall) begin
            if (cntFull) nextState   = ST_TX_ACK;
            else         st.shiftOut = 1'b1;
          end
        end
        ST_TX_ACK: begin
          if (ev.sclFall) begin
            if (masterAck) begin
              st.loadTx = 1'b1;
              st.clrCnt = 1'b1;
              nextState = ST_TX;
            end else begin
              nextState = ST_SKIP;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_slave_core.sv
module i2c_slave_core
  import i2cs_pkg::*;
#(
  parameter int         SYNC_STAGES  = 2,
  parameter logic [7:0] OWN_ADDR_RST = 8'hA0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaDriveLow,
  input  logic       ownAddrWr,
  input  logic [7:0] ownAddrIn,
  input  logic [7:0] txData,
  output logic       txTaken,
  output logic [7:0] rxData,
  output logic       rxValid
);

  localparam int DATA_W = 8;

  busEv_t  ev;
  strobe_t st;
  state_e  ctlState;
  logic    sdaBit, cntFull, cntLast, addrHit, rwBit;
  logic    startSeen, stopSeen;

  i2cs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ev(ev), .sdaBit(sdaBit)
  );

  i2cs_control u_ctl (
    .clk(clk), .rstN(rstN), .ev(ev), .sdaBit(sdaBit),
    .cntFull(cntFull), .cntLast(cntLast), .addrHit(addrHit), .rwBit(rwBit),
    .st(st), .state(ctlState)
  );

  i2cs_datapath #(.DATA_W(DATA_W), .OWN_ADDR_RST(OWN_ADDR_RST)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .sdaBit(sdaBit),
    .ownAddrWr(ownAddrWr), .ownAddrIn(ownAddrIn), .txData(txData),
    .cntFull(cntFull), .cntLast(cntLast), .addrHit(addrHit), .rwBit(rwBit),
    .rxData(rxData), .rxValid(rxValid), .txTaken(txTaken),
    .sdaDriveLow(sdaDriveLow)
  );

  assign startSeen = ev.startCond;
  assign stopSeen  = ev.stopCond;

endmodule

// File: rtl/i2c_slave_core_checker.sv
module i2c_slave_core_checker
  import i2cs_pkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   sclIn,
  input logic   sdaDriveLow,
  input logic   rxValid,
  input logic   startSeen,
  input logic   stopSeen,
  input state_e ctlState
);

  AST_RX_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R3

  AST_RX_FROM_RX: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(ctlState) == ST_RX); // R3

  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> ctlState == ST_ADDR); // R7

  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> ctlState == ST_IDLE); // R8

  AST_PULL_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclIn); // R9

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_SKIP && $past(ctlState) == ST_SKIP) |-> !sdaDriveLow); // R4

endmodule

bind i2c_slave_core i2c_slave_core_checker u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .rxValid(rxValid), .startSeen(startSeen), .stopSeen(stopSeen),
  .ctlState(ctlState)
);

// File: tb/i2c_slave_core_bench.sv
module i2c_slave_core_bench;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic ownAddrWr = 1'b0;
  logic [7:0] ownAddrIn = 8'h00;
  logic [7:0] txData = 8'h00;
  logic sdaDriveLow, txTaken, rxValid;
  logic [7:0] rxData;
  logic sdaLine;

  int checks = 0;
  int errors = 0;
  int rxCount = 0;
  int txCount = 0;
  logic [7:0] rxExp[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sdaLine = sdaM & ~sdaDriveLow;

  i2c_slave_core #(.SYNC_STAGES(3), .OWN_ADDR_RST(8'h54)) u_i2c_slave_core (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .ownAddrWr(ownAddrWr), .ownAddrIn(ownAddrIn),
    .txData(txData), .txTaken(txTaken), .rxData(rxData), .rxValid(rxValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard for received bytes
  always @(negedge clk) begin
    if (rstN && rxValid) begin
      rxCount++;
      if (rxExp.size() == 0) begin
        check(1'b0, "R3 unexpected rxValid", rxData, 0);
      end else begin
        automatic logic [7:0] e = rxExp.pop_front();
        check(rxData == e, "R3 received byte", rxData, e);
      end
    end
    if (rstN && txTaken) txCount++;
  end

  task automatic waitQ(input int n);
    repeat (n * Q) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b1; waitQ(2);
  endtask

  task automatic bitOut(input logic b);
    sdaM = b;    waitQ(1);
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic bitIn(output logic b);
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    b = sdaLine; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic writeByte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) bitOut(d[i]);
    bitIn(ack);
  endtask

  task automatic readBits(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      bitIn(b);
      d[i] = b;
    end
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    int rxBase;

    repeat (5) @(posedge clk);
    #1;
    check(sdaDriveLow == 1'b0, "R1 drive after reset", sdaDriveLow, 0);
    check(rxValid == 1'b0, "R1 rxValid after reset", rxValid, 0);
    rstN = 1'b1;
    waitQ(1);
    check(sdaDriveLow == 1'b0, "R1 idle drive", sdaDriveLow, 0);

    // R2 / R3: write two bytes to the reset address 0x2A
    busStart();
    writeByte({7'h2A, 1'b0}, ack);
    check(ack == 1'b0, "R2 address ack", ack, 0);
    rxExp.push_back(8'hA5);
    writeByte(8'hA5, ack);
    check(ack == 1'b0, "R3 data ack 1", ack, 0);
    rxExp.push_back(8'h3C);
    writeByte(8'h3C, ack);
    check(ack == 1'b0, "R3 data ack 2", ack, 0);
    busStop();
    check(rxCount == 2, "R3 byte count", rxCount, 2);

    // R4: mismatching address
    rxBase = rxCount;
    busStart();
    writeByte({7'h2B, 1'b0}, ack);
    check(ack == 1'b1, "R4 no address ack", ack, 1);
    writeByte(8'h00, ack);
    check(ack == 1'b1, "R4 no data ack", ack, 1);
    busStop();
    check(rxCount == rxBase, "R4 no rxValid", rxCount, rxBase);

    // R5 / R6: read two bytes, NACK the second
    txData = 8'h96;
    busStart();
    writeByte({7'h2A, 1'b1}, ack);
    check(ack == 1'b0, "R2 read address ack", ack, 0);
    readBits(d);
    check(d == 8'h96, "R5 first sent byte", d, 8'h96);
    txData = 8'h5A;
    bitOut(1'b0);
    readBits(d);
    check(d == 8'h5A, "R5 second sent byte", d, 8'h5A);
    txData = 8'h00;
    bitOut(1'b1);
    readBits(d);
    check(d == 8'hFF, "R6 released after NACK", d, 8'hFF);
    busStop();
    check(txCount == 2, "R5 txTaken count", txCount, 2);

    // R7: repeated START after a full byte, turn to read
    busStart();
    writeByte({7'h2A, 1'b0}, ack);
    rxExp.push_back(8'h11);
    writeByte(8'h11, ack);
    check(ack == 1'b0, "R3 ack before restart", ack, 0);
    txData = 8'hC3;
    busStart();
    writeByte({7'h2A, 1'b1}, ack);
    check(ack == 1'b0, "R7 address ack after restart", ack, 0);
    readBits(d);
    check(d == 8'hC3, "R7 byte after restart", d, 8'hC3);
    bitOut(1'b1);
    busStop();

    // R7: repeated START in the middle of a byte
    busStart();
    writeByte({7'h2A, 1'b0}, ack);
    for (int i = 0; i < 4; i++) bitOut(1'b1);
    busStart();
    writeByte({7'h2A, 1'b0}, ack);
    check(ack == 1'b0, "R7 mid-byte restart ack", ack, 0);
    rxExp.push_back(8'h77);
    writeByte(8'h77, ack);
    busStop();

    // R8: bits clocked after STOP without START are ignored
    rxBase = rxCount;
    writeByte({7'h2A, 1'b0}, ack);
    check(ack == 1'b1, "R8 no ack without start", ack, 1);
    writeByte(8'h55, ack);
    check(ack == 1'b1, "R8 no data ack without start", ack, 1);
    check(rxCount == rxBase, "R8 no rxValid", rxCount, rxBase);
    busStop();

    // R10: new own address 0x7F, bit 0 set and ignored
    ownAddrIn = 8'hFF;
    ownAddrWr = 1'b1;
    @(posedge clk); #1;
    ownAddrWr = 1'b0;
    busStart();
    writeByte({7'h2A, 1'b0}, ack);
    check(ack == 1'b1, "R10 old address rejected", ack, 1);
    busStop();
    busStart();
    writeByte({7'h7F, 1'b0}, ack);
    check(ack == 1'b0, "R10 new address ack", ack, 0);
    rxExp.push_back(8'h42);
    writeByte(8'h42, ack);
    busStop();

    check(rxExp.size() == 0, "R3 scoreboard drained", rxExp.size(), 0);
    check(sdaDriveLow == 1'b0, "R8 idle after stop", sdaDriveLow, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule